// File: doc/BRIEF.md
# Indexed Bit-Operation Instruction Executor

This block carries out the indexed bit-operation group of an 8-bit CPU after the prefix bytes have been decoded. The sequencer hands it the signed displacement, the final opcode byte, the index register, the current carry flag and the refresh counter, and raises `start` for one cycle. The block adds the sign-extended displacement to the index register to form the operand address. It reads the operand byte through a request/ready memory port and applies one of four operation classes: rotate/shift, bit test, bit clear or bit set.

Modifying forms store the new byte back to the same address. Unless the low three opcode bits equal 6, they also hand the byte to a general register. Test forms write nothing. Instead they produce a flag byte, whose two undocumented bits come from the high byte of the address. Every form loads the hidden address latch with the operand address. Every form reports its T-state count and the refresh counter advanced by two, all during a single-cycle `done` pulse.

Top module: `idx_bitop_exec`

## Requirements
- R1: The operand address is `index_reg` plus the 8-bit displacement sign-extended to 16 bits, wrapping modulo 65536. The read of each instruction uses this address, and so does the write of each modifying instruction.
- R2: Opcode bits 7:6 pick the class: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set.
- R3: For rotate/shift, opcode bits 5:3 pick the operation. 0: rotate left circular. 1: rotate right circular. 2: rotate left through `carry_in`. 3: rotate right through `carry_in`. 4: arithmetic shift left. 5: arithmetic shift right, which keeps bit 7. 6: shift left with a 1 entering bit 0. 7: logical shift right.
- R4: For bit clear and bit set, opcode bits 5:3 give the bit number. The result is the operand with only that bit forced to 0 or to 1.
- R5: A modifying form issues exactly one memory write, carrying the result. When opcode bits 2:0 are not 6, it also pulses `reg_we` with `reg_sel` equal to opcode bits 2:0 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 7 A) and `reg_wdata` equal to the result. When those bits are 6, `reg_we` stays low.
- R6: A bit-test form issues no memory write and no register write.
- R7: A bit-test form pulses `flags_we`. In `flags_out`, the bits are laid out as S=7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. Z and P/V are set when the tested bit is 0. H is 1 and N is 0. S is set only when bit 7 is tested and found set. Y and X copy bits 5 and 3 of the address's high byte. C equals `carry_in`. Modifying forms leave `flags_we` low.
- R8: Every form pulses `wz_we` during `done`, with `wz_value` equal to the operand address.
- R9: `tstates` reads 20 for a bit-test form and 23 for every modifying form while `done` is high.
- R10: While `done` is high, `refresh_out` equals `refresh_in` as it was at `start`, with bit 7 kept and bits 6:0 advanced by 2 modulo 128.
- R11: `mem_req` holds with a stable address and direction until `mem_ready` is seen. `done` lasts exactly one cycle. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction (taken only when idle) |
| disp | input | 8 | Signed displacement byte |
| opcode | input | 8 | Final opcode byte |
| index_reg | input | 16 | Index register value |
| carry_in | input | 1 | Current carry flag |
| refresh_in | input | 8 | Refresh counter before the instruction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_we | output | 1 | General register write strobe |
| reg_sel | output | 3 | General register code |
| reg_wdata | output | 8 | General register write data |
| flags_we | output | 1 | Flag byte write strobe |
| flags_out | output | 8 | Flag byte |
| wz_we | output | 1 | Hidden address latch load strobe |
| wz_value | output | 16 | Hidden address latch value |
| tstates | output | 5 | T-state count of the instruction |
| refresh_out | output | 8 | Refresh counter after the instruction |

## Verification
The hardest case to reach from the ports is a second `start` that arrives while an instruction is in flight and memory is stalling. The second start carries a different opcode and displacement, so it would be visible if it leaked in. A directed run raises it for two cycles right after the first start, while the bench's memory model holds `mem_ready` back. The bench then checks that the result, write address and register code all belong to the first instruction. Random latencies from zero to three cycles in front of every access also exercise the request hold on both read and write. Directed cases cover address wrap in both directions, the shift that fills bit 0 with a 1, and refresh wrap with bit 7 set.

// File: rtl/idx_bitop_pkg.sv
// Shared types for the indexed bit-operation executor.
// Assumes an 8-bit data path; class codes match opcode bits 7:6.
package idx_bitop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_EXEC  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } exec_state_t;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_TEST  = 2'b01,
        CLS_CLEAR = 2'b10,
        CLS_SET   = 2'b11
    } op_class_t;

    // Flag byte bit positions
    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_Y  = 5;
    localparam int FB_H  = 4;
    localparam int FB_X  = 3;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    // Register code meaning "memory only"
    localparam logic [2:0] REG_MEM_ONLY = 3'd6;

endpackage

// File: rtl/idx_bitop_agen.sv
// Operand address generator: index plus sign-extended displacement.
// Assumes ADDR_W >= 8; the sum wraps modulo 2**ADDR_W.
module idx_bitop_agen #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [7:0]        offset,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - 8;

    // Sign-extend the offset and add it to the base
    always_comb begin
        addr = base + {{EXT_W{offset[7]}}, offset};
    end
endmodule

// File: rtl/idx_bitop_alu.sv
// Combinational operation unit: rotate/shift, bit test, bit clear, bit set.
// Assumes an 8-bit operand; the flag byte is meaningful for the test class only.
module idx_bitop_alu
    import idx_bitop_pkg::*;
(
    input  op_class_t  cls,
    input  logic [2:0] sub,
    input  logic [7:0] operand,
    input  logic       carry_in,
    input  logic       y_src,
    input  logic       x_src,
    output logic [7:0] result,
    output logic [7:0] flags
);
    logic [7:0] bit_mask;
    logic [7:0] shifted;
    logic       tested;

    // One-hot mask of the selected bit number
    for (genvar i = 0; i < 8; i++) begin : g_mask
        assign bit_mask[i] = (sub == 3'(i));
    end

    // Rotate or shift chosen by the sub-operation code
    always_comb begin
        unique case (sub)
            3'd0: shifted = {operand[6:0], operand[7]};
            3'd1: shifted = {operand[0], operand[7:1]};
            3'd2: shifted = {operand[6:0], carry_in};
            3'd3: shifted = {carry_in, operand[7:1]};
            3'd4: shifted = {operand[6:0], 1'b0};
            3'd5: shifted = {operand[7], operand[7:1]};
            3'd6: shifted = {operand[6:0], 1'b1};
            default: shifted = {1'b0, operand[7:1]};
        endcase
    end

    // Result selection by class
    always_comb begin
        unique case (cls)
            CLS_SHIFT: result = shifted;
            CLS_CLEAR: result = operand & ~bit_mask;
            CLS_SET:   result = operand | bit_mask;
            default:   result = operand;
        endcase
    end

    // Bit-test flag byte
    always_comb begin
        tested       = |(operand & bit_mask);
        flags        = 8'h00;
        flags[FB_S]  = tested & bit_mask[7];
        flags[FB_Z]  = ~tested;
        flags[FB_Y]  = y_src;
        flags[FB_H]  = 1'b1;
        flags[FB_X]  = x_src;
        flags[FB_PV] = ~tested;
        flags[FB_N]  = 1'b0;
        flags[FB_C]  = carry_in;
    end
endmodule

// File: rtl/idx_bitop_ctrl.sv
// Sequencer: idle, operand read, execute, write-back, completion.
// Assumes mem_ready is sampled only while a request is outstanding.
module idx_bitop_ctrl
    import idx_bitop_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        is_test,
    input  logic        mem_ready,
    output exec_state_t state
);
    exec_state_t nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_READ;
            ST_READ:  if (mem_ready) nxt = ST_EXEC;
            ST_EXEC:  nxt = is_test ? ST_DONE : ST_WRITE;
            ST_WRITE: if (mem_ready) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/idx_bitop_exec.sv
// Top of the indexed bit-operation executor.
// Latches the instruction on start, reads the operand, computes, writes back
// modifying forms, and reports register, flag, latch, T-state and refresh
// updates during a one-cycle done pulse. Assumes start is only acted on idle.
module idx_bitop_exec
    import idx_bitop_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int TS_W      = 5,
    parameter int TS_TEST   = 20,
    parameter int TS_MODIFY = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        disp,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] index_reg,
    input  logic              carry_in,
    input  logic [7:0]        refresh_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              reg_we,
    output logic [2:0]        reg_sel,
    output logic [7:0]        reg_wdata,
    output logic              flags_we,
    output logic [7:0]        flags_out,
    output logic              wz_we,
    output logic [ADDR_W-1:0] wz_value,
    output logic [TS_W-1:0]   tstates,
    output logic [7:0]        refresh_out
);
    localparam int HI_LSB = ADDR_W - 8;

    exec_state_t       state;
    logic [ADDR_W-1:0] ea_next;
    logic [ADDR_W-1:0] ea_q;
    logic [7:0]        op_q;
    logic              carry_q;
    logic [7:0]        refresh_q;
    logic [7:0]        operand_q;
    logic [7:0]        result_q;
    logic [7:0]        flags_q;
    logic [7:0]        alu_result;
    logic [7:0]        alu_flags;
    logic              is_test;
    logic              take;

    assign take    = (state == ST_IDLE) && start;
    assign is_test = (op_class_t'(op_q[7:6]) == CLS_TEST);

    idx_bitop_agen #(.ADDR_W(ADDR_W)) u_agen (
        .base   (index_reg),
        .offset (disp),
        .addr   (ea_next)
    );

    idx_bitop_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_test   (is_test),
        .mem_ready (mem_ready),
        .state     (state)
    );

    idx_bitop_alu u_alu (
        .cls      (op_class_t'(op_q[7:6])),
        .sub      (op_q[5:3]),
        .operand  (operand_q),
        .carry_in (carry_q),
        .y_src    (ea_q[HI_LSB+5]),
        .x_src    (ea_q[HI_LSB+3]),
        .result   (alu_result),
        .flags    (alu_flags)
    );

    // Instruction latch, loaded when an idle start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q      <= '0;
            op_q      <= '0;
            carry_q   <= 1'b0;
            refresh_q <= '0;
        end else if (take) begin
            ea_q      <= ea_next;
            op_q      <= opcode;
            carry_q   <= carry_in;
            refresh_q <= refresh_in;
        end
    end

    // Operand capture when the read completes
    always_ff @(posedge clk) begin
        if (!rst_n)                              operand_q <= '0;
        else if (state == ST_READ && mem_ready)  operand_q <= mem_rdata;
    end

    // Result and flag capture in the execute step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
        end else if (state == ST_EXEC) begin
            result_q <= alu_result;
            flags_q  <= alu_flags;
        end
    end

    // Memory port driven from the state
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = ea_q;
        mem_wdata = result_q;
    end

    // Completion outputs, valid while done is high
    always_comb begin
        busy        = (state != ST_IDLE);
        done        = (state == ST_DONE);
        reg_sel     = op_q[2:0];
        reg_wdata   = result_q;
        reg_we      = done && !is_test && (op_q[2:0] != REG_MEM_ONLY);
        flags_we    = done && is_test;
        flags_out   = flags_q;
        wz_we       = done;
        wz_value    = ea_q;
        tstates     = is_test ? TS_W'(TS_TEST) : TS_W'(TS_MODIFY);
        refresh_out = {refresh_q[7], refresh_q[6:0] + 7'd2};
    end
endmodule

// File: rtl/idx_bitop_exec_chk.sv
// Property checker for idx_bitop_exec, bound to every instance of the top.
module idx_bitop_exec_chk #(
    parameter int ADDR_W    = 16,
    parameter int TS_W      = 5,
    parameter int TS_TEST   = 20,
    parameter int TS_MODIFY = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              flags_we,
    input logic              wz_we,
    input logic [ADDR_W-1:0] wz_value,
    input logic [TS_W-1:0]   tstates
);
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);

    a_r5_reg_code: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> done && reg_sel != 3'd6);

    a_r6_test_silent: assert property (@(posedge clk) disable iff (!rst_n)
        done && tstates == TS_W'(TS_TEST) |-> !reg_we && flags_we);

    a_r9_tstate_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tstates == TS_W'(TS_TEST) || tstates == TS_W'(TS_MODIFY));

    a_r8_latch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wz_we && wz_value == mem_addr);
endmodule

bind idx_bitop_exec idx_bitop_exec_chk #(
    .ADDR_W(ADDR_W), .TS_W(TS_W), .TS_TEST(TS_TEST), .TS_MODIFY(TS_MODIFY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .flags_we  (flags_we),
    .wz_we     (wz_we),
    .wz_value  (wz_value),
    .tstates   (tstates)
);

// File: tb/idx_bitop_exec_tb.sv
// Self-checking bench: seeded random instructions plus directed corners.
module idx_bitop_exec_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  disp = '0;
    logic [7:0]  opcode = '0;
    logic [15:0] index_reg = '0;
    logic        carry_in = 1'b0;
    logic [7:0]  refresh_in = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy, done, reg_we, flags_we, wz_we;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata, flags_out, refresh_out;
    logic [15:0] wz_value;
    logic [4:0]  tstates;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // Memory model state
    logic [7:0]  mem_byte = '0;
    int          wait_cnt = 0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [15:0] rd_addr = '0, wr_addr = '0;
    logic [7:0]  wr_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_bitop_exec u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .disp(disp), .opcode(opcode),
        .index_reg(index_reg), .carry_in(carry_in), .refresh_in(refresh_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .flags_we(flags_we), .flags_out(flags_out),
        .wz_we(wz_we), .wz_value(wz_value), .tstates(tstates),
        .refresh_out(refresh_out)
    );

    // Memory responder with random latency, acting on falling edges
    always @(negedge clk) begin
        mem_ready <= 1'b0;
        if (mem_req && !mem_ready) begin
            if (wait_cnt == 0) begin
                mem_ready <= 1'b1;
                mem_rdata <= mem_byte;
                wait_cnt  <= int'($urandom % 4);
                if (mem_we) begin
                    wr_cnt  <= wr_cnt + 1;
                    wr_addr <= mem_addr;
                    wr_data <= mem_wdata;
                end else begin
                    rd_cnt  <= rd_cnt + 1;
                    rd_addr <= mem_addr;
                end
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    function automatic logic [15:0] f_ea(input logic [15:0] idx, input logic [7:0] d);
        return idx + {{8{d[7]}}, d};
    endfunction

    function automatic logic [7:0] f_result(input logic [7:0] op, input logic [7:0] v,
                                            input logic c);
        logic [7:0] m;
        m = 8'h01 << op[5:3];
        case (op[7:6])
            2'b00: case (op[5:3])
                3'd0: return {v[6:0], v[7]};
                3'd1: return {v[0], v[7:1]};
                3'd2: return {v[6:0], c};
                3'd3: return {c, v[7:1]};
                3'd4: return {v[6:0], 1'b0};
                3'd5: return {v[7], v[7:1]};
                3'd6: return {v[6:0], 1'b1};
                default: return {1'b0, v[7:1]};
            endcase
            2'b10: return v & ~m;
            2'b11: return v | m;
            default: return v;
        endcase
    endfunction

    function automatic logic [7:0] f_flags(input logic [7:0] op, input logic [7:0] v,
                                           input logic c, input logic [15:0] ea);
        logic b;
        b = v[op[5:3]];
        return {(op[5:3] == 3'd7) & b, ~b, ea[13], 1'b1, ea[11], ~b, 1'b0, c};
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one instruction and check every reported effect
    task automatic run(input logic [7:0] op, input logic [7:0] d, input logic [15:0] idx,
                       input logic c, input logic [7:0] val, input logic [7:0] r,
                       input bit intrude);
        logic [15:0] ea;
        logic [7:0]  res;
        int          guard;
        logic        s_rwe, s_fwe, s_wzwe;
        logic [2:0]  s_sel;
        logic [7:0]  s_rd, s_fl, s_rf;
        logic [15:0] s_wz;
        logic [4:0]  s_ts;
        ea  = f_ea(idx, d);
        res = f_result(op, val, c);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        mem_byte = val;
        opcode = op; disp = d; index_reg = idx; carry_in = c; refresh_in = r;
        start = 1'b1;
        @(negedge clk);
        if (intrude) begin
            opcode = ~op; disp = d + 8'h33; index_reg = idx ^ 16'h5A5A;
            carry_in = ~c; refresh_in = r + 8'h11;
            @(negedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        if (!done) begin
            check(0, "R11 hang", 16'h0, 16'h1);
            return;
        end
        s_rwe = reg_we; s_sel = reg_sel; s_rd = reg_wdata; s_fwe = flags_we;
        s_fl = flags_out; s_wzwe = wz_we; s_wz = wz_value; s_ts = tstates;
        s_rf = refresh_out;
        // R1 read address and count
        check(rd_cnt == 1 && rd_addr == ea, "R1 read addr", rd_addr, ea);
        if (op[7:6] == 2'b01) begin
            check(wr_cnt == 0, "R6 no mem write", 16'(wr_cnt), 16'h0);
            check(!s_rwe, "R6 no reg write", 16'(s_rwe), 16'h0);
            check(s_fwe, "R7 flags strobe", 16'(s_fwe), 16'h1);
            check(s_fl == f_flags(op, val, c, ea), "R7 flag byte",
                  16'(s_fl), 16'(f_flags(op, val, c, ea)));
            check(s_ts == 5'd20, "R9 test tstates", 16'(s_ts), 16'd20);
        end else begin
            check(wr_cnt == 1 && wr_addr == ea, "R1 R5 write addr", wr_addr, ea);
            check(wr_data == res, (op[7:6] == 2'b00) ? "R3 R2 shift result" : "R4 R2 bit result",
                  16'(wr_data), 16'(res));
            check(s_rwe == (op[2:0] != 3'd6), "R5 reg strobe", 16'(s_rwe),
                  16'(op[2:0] != 3'd6));
            if (op[2:0] != 3'd6)
                check(s_sel == op[2:0] && s_rd == res, "R5 reg data",
                      {5'd0, s_sel, s_rd}, {5'd0, op[2:0], res});
            check(!s_fwe, "R7 no flags on modify", 16'(s_fwe), 16'h0);
            check(s_ts == 5'd23, "R9 modify tstates", 16'(s_ts), 16'd23);
        end
        check(s_wzwe && s_wz == ea, "R8 latch", s_wz, ea);
        check(s_rf == {r[7], r[6:0] + 7'd2}, "R10 refresh", 16'(s_rf),
              16'({r[7], r[6:0] + 7'd2}));
        @(negedge clk);
        check(!done, "R11 done one cycle", 16'(done), 16'h0);
    endtask

    // Global watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req, "R11 reset idle",
              {13'd0, busy, done, mem_req}, 16'h0);
        rst_n = 1'b1;
        // Directed corners
        run(8'h46, 8'h80, 16'h0010, 1'b0, 8'h00, 8'h00, 0); // R1 wrap down, test bit 0 clear
        run(8'hC6, 8'h7F, 16'hFFF0, 1'b0, 8'h00, 8'h7F, 0); // R1 wrap up, R10 wrap
        run(8'h7E, 8'h05, 16'h2800, 1'b1, 8'h80, 8'hFF, 0); // R7 S set, Y/X from high byte
        run(8'h37, 8'h01, 16'h1000, 1'b0, 8'h00, 8'h10, 0); // R3 fill bit 0 with 1, reg A
        run(8'h16, 8'hFE, 16'h4000, 1'b1, 8'h40, 8'h00, 0); // R3 rotate through carry, mem only
        run(8'hB8, 8'h02, 16'h3000, 1'b0, 8'hFF, 8'h20, 0); // R4 clear bit 7, reg B
        run(8'h2D, 8'h03, 16'h5000, 1'b0, 8'h81, 8'h30, 1); // R11 start while busy, SRA to L
        // Random stream
        for (int k = 0; k < 400; k++) begin
            run(8'($urandom), 8'($urandom), 16'($urandom), 1'($urandom),
                8'($urandom), 8'($urandom), (k % 37) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule